// File: doc/BRIEF.md
# Capability Access Checker

This block decides whether a memory access made through a capability may go ahead. For a data or instruction access it takes the capability's validity tag, sealed flag, execute/load/store permissions, base, offset and length, together with an address operand, an access kind and an access size. It returns either the 64-bit virtual address of the access or a violation code and a register number. The tests run in a fixed priority order.

A second, independent path checks an instruction fetch against the program-counter capability. It returns the absolute fetch address and flags a misaligned fetch or a fetch that runs past the capability's length.

Both paths compute in one combinational stage and register the result, so a response appears one clock after its request. Address translation, the capability register file and exception dispatch belong to the surrounding pipeline.

Top module: `cap_access_checker`

## Requirements
- R1: A response is registered. `rsp_valid` is high exactly one clock after a cycle with `req_valid` high, and `fetch_rsp_valid` is high exactly one clock after `fetch_valid`. While `rst_n` is low at a clock edge, every output is cleared to zero.
- R2: A capability with its tag clear gives violation code 0x02, whatever the other inputs are.
- R3: A tagged capability that is sealed gives code 0x03, ahead of all permission and bounds tests.
- R4: The access kind selects the permission that is needed: kind 0 (instruction) needs execute and fails with 0x11, kind 1 (load) needs load and fails with 0x12, and kind 2 (store) needs store and fails with 0x13. Kind 3 is checked as a store. A permission failure takes priority over a bounds failure.
- R5: The reported address is (base + offset + address operand) mod 2^64. It is given on every data response.
- R6: `acc_size_sel` values 0, 1, 2 and 3 select sizes of 1, 2, 4 and 8 bytes. Code 0x01 is raised when the unwrapped sum of the cursor ((base + offset) mod 2^64), the address operand and the size is greater than base + length, with that sum also taken without wrap.
- R7: Code 0x01 is also raised when the cursor plus the address operand is below base. This includes the case where base + offset wraps past 2^64.
- R8: A data response always reports register number 0. A response with no violation has `rsp_fault` low and code 0x00, and any violation has `rsp_fault` high.
- R9: The fetch path reports the fetch address (pcc_base + pcc_offset) mod 2^64. It raises `fetch_addr_err` when bits 1..0 of that address are not both zero. A misaligned fetch reports no length fault.
- R10: An aligned fetch with pcc_offset + 4 > pcc_length, computed without wrap, raises `fetch_len_fault` with code 0x01 and register number 0xFF. Otherwise the fetch code and register number are 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Data/instruction access request this cycle |
| cap_tag | input | 1 | Capability validity tag |
| cap_sealed | input | 1 | Capability is sealed |
| cap_perm_exec | input | 1 | Execute permission |
| cap_perm_load | input | 1 | Load permission |
| cap_perm_store | input | 1 | Store permission |
| cap_base | input | 64 | Capability base |
| cap_offset | input | 64 | Capability offset |
| cap_length | input | 64 | Capability length |
| acc_addr | input | 64 | Unsigned address operand added to the cursor |
| acc_kind | input | 2 | 0 instruction, 1 load, 2 store, 3 checked as store |
| acc_size_sel | input | 2 | Access size: 1 shifted left by this value, in bytes |
| fetch_valid | input | 1 | Instruction fetch check request |
| pcc_base | input | 64 | Program-counter capability base |
| pcc_offset | input | 64 | Program-counter offset |
| pcc_length | input | 64 | Program-counter capability length |
| rsp_valid | output | 1 | Data response valid |
| rsp_fault | output | 1 | Data access violated the capability |
| rsp_code | output | 8 | Violation code, 0x00 when none |
| rsp_regnum | output | 8 | Register number of the violation |
| rsp_addr | output | 64 | Computed virtual address |
| fetch_rsp_valid | output | 1 | Fetch response valid |
| fetch_addr_err | output | 1 | Fetch address misaligned |
| fetch_len_fault | output | 1 | Fetch past capability length |
| fetch_code | output | 8 | Fetch violation code |
| fetch_regnum | output | 8 | Fetch violation register number (0xFF) |
| fetch_pc | output | 64 | Absolute fetch address |

## Verification
The assertions assume that every request input is steady and known on the clock edge where its valid is sampled. They also assume that `acc_kind` and `acc_size_sel` carry only their four defined codes. The stimulus drives all inputs on the falling edge and raises each valid only alongside fully set fields. It sweeps all combinations of tag, seal, the three permissions and the four kinds. It then sweeps offsets and sizes across both bounds of a small window, adds cases near 2^64 where the cursor or the address wraps, and sweeps fetch offsets, base alignment and lengths around the four-byte limit.

// File: rtl/cap_chk_pkg.sv
// Shared codes and encodings for the capability access checker.
// Assumes nothing beyond 8-bit violation codes and register numbers.
package cap_chk_pkg;

    typedef logic [7:0] exc_code_t;

    typedef enum logic [1:0] {
        KIND_INSTR = 2'd0,
        KIND_LOAD  = 2'd1,
        KIND_STORE = 2'd2,
        KIND_RSVD  = 2'd3
    } acc_kind_e;

    localparam exc_code_t EXC_NONE   = 8'h00;
    localparam exc_code_t EXC_LENGTH = 8'h01;
    localparam exc_code_t EXC_TAG    = 8'h02;
    localparam exc_code_t EXC_SEAL   = 8'h03;
    localparam exc_code_t EXC_EXEC   = 8'h11;
    localparam exc_code_t EXC_LOAD   = 8'h12;
    localparam exc_code_t EXC_STORE  = 8'h13;

    localparam logic [7:0] REG_DATA_CAP = 8'h00;
    localparam logic [7:0] REG_NONE     = 8'hFF;

endpackage

// File: rtl/cap_perm_check.sv
// Tag, seal and access-kind permission tests, in priority order.
// Purely combinational. The reserved kind is checked like a store.
module cap_perm_check
    import cap_chk_pkg::*;
(
    input  logic       tag,
    input  logic       sealed,
    input  logic       perm_exec,
    input  logic       perm_load,
    input  logic       perm_store,
    input  logic [1:0] kind,
    output logic       fault,
    output exc_code_t  code
);

    // Pick the permission and the failure code that the access kind needs.
    logic      need_ok;
    exc_code_t need_code;
    always_comb begin
        case (acc_kind_e'(kind))
            KIND_INSTR: begin need_ok = perm_exec; need_code = EXC_EXEC;  end
            KIND_LOAD:  begin need_ok = perm_load; need_code = EXC_LOAD;  end
            default:    begin need_ok = perm_store; need_code = EXC_STORE; end
        endcase
    end

    // Resolve in priority order: tag, then seal, then permission.
    always_comb begin
        fault = 1'b1;
        if (!tag)          code = EXC_TAG;
        else if (sealed)   code = EXC_SEAL;
        else if (!need_ok) code = need_code;
        else begin
            fault = 1'b0;
            code  = EXC_NONE;
        end
    end

endmodule

// File: rtl/cap_bounds_check.sv
// Forms the access address and tests it against [base, base+length).
// Assumes size_sel encodes 2**size_sel bytes. Bounds compare in
// ADDR_W+2 bits so that no sum above 2**ADDR_W wraps.
module cap_bounds_check #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] length,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size_sel,
    output logic [ADDR_W-1:0] vaddr,
    output logic              fault
);

    localparam int EXT_W = ADDR_W + 2;

    logic [ADDR_W-1:0] cursor;
    logic [EXT_W-1:0]  vaddr_ext;
    logic [EXT_W-1:0]  end_ext;
    logic [EXT_W-1:0]  limit_ext;
    logic [EXT_W-1:0]  base_ext;
    logic [EXT_W-1:0]  size_ext;

    // Cursor wraps; the address operand is then added without wrap.
    always_comb begin
        cursor    = base + offset;
        base_ext  = {2'b00, base};
        vaddr_ext = {2'b00, cursor} + {2'b00, addr};
        size_ext  = EXT_W'(1) << size_sel;
        end_ext   = vaddr_ext + size_ext;
        limit_ext = base_ext + {2'b00, length};
    end

    // Truncated address and the two bound tests.
    always_comb begin
        vaddr = vaddr_ext[ADDR_W-1:0];
        fault = (end_ext > limit_ext) || (vaddr_ext < base_ext);
    end

endmodule

// File: rtl/cap_fetch_check.sv
// Instruction fetch test against the program-counter capability.
// Misalignment has priority over the length test. Assumes 4-byte fetches.
module cap_fetch_check #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    input  logic [ADDR_W-1:0] length,
    output logic [ADDR_W-1:0] pc,
    output logic              misaligned,
    output logic              len_fault
);

    localparam int EXT_W   = ADDR_W + 1;
    localparam int FETCH_B = 4;

    logic [EXT_W-1:0] end_ext;

    // Absolute address, alignment, then the unwrapped length test.
    always_comb begin
        pc         = base + offset;
        misaligned = |pc[1:0];
        end_ext    = {1'b0, offset} + EXT_W'(FETCH_B);
        len_fault  = !misaligned && (end_ext > {1'b0, length});
    end

endmodule

// File: rtl/cap_access_checker.sv
// Capability access checker top. It combines the permission and bounds
// results for data accesses, runs the fetch check, and registers both with
// one cycle of latency. Assumes inputs are stable at the sampling edge.
module cap_access_checker
    import cap_chk_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              cap_tag,
    input  logic              cap_sealed,
    input  logic              cap_perm_exec,
    input  logic              cap_perm_load,
    input  logic              cap_perm_store,
    input  logic [ADDR_W-1:0] cap_base,
    input  logic [ADDR_W-1:0] cap_offset,
    input  logic [ADDR_W-1:0] cap_length,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic [1:0]        acc_size_sel,
    input  logic              fetch_valid,
    input  logic [ADDR_W-1:0] pcc_base,
    input  logic [ADDR_W-1:0] pcc_offset,
    input  logic [ADDR_W-1:0] pcc_length,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [7:0]        rsp_code,
    output logic [7:0]        rsp_regnum,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              fetch_rsp_valid,
    output logic              fetch_addr_err,
    output logic              fetch_len_fault,
    output logic [7:0]        fetch_code,
    output logic [7:0]        fetch_regnum,
    output logic [ADDR_W-1:0] fetch_pc
);

    logic              perm_fault;
    exc_code_t         perm_code;
    logic              bnd_fault;
    logic [ADDR_W-1:0] bnd_vaddr;
    logic [ADDR_W-1:0] f_pc;
    logic              f_mis;
    logic              f_len;

    cap_perm_check u_perm (
        .tag        (cap_tag),
        .sealed     (cap_sealed),
        .perm_exec  (cap_perm_exec),
        .perm_load  (cap_perm_load),
        .perm_store (cap_perm_store),
        .kind       (acc_kind),
        .fault      (perm_fault),
        .code       (perm_code)
    );

    cap_bounds_check #(.ADDR_W(ADDR_W)) u_bnd (
        .base     (cap_base),
        .offset   (cap_offset),
        .length   (cap_length),
        .addr     (acc_addr),
        .size_sel (acc_size_sel),
        .vaddr    (bnd_vaddr),
        .fault    (bnd_fault)
    );

    cap_fetch_check #(.ADDR_W(ADDR_W)) u_fetch (
        .base       (pcc_base),
        .offset     (pcc_offset),
        .length     (pcc_length),
        .pc         (f_pc),
        .misaligned (f_mis),
        .len_fault  (f_len)
    );

    // Merge: a permission result outranks a bounds result.
    logic      d_fault;
    exc_code_t d_code;
    always_comb begin
        if (perm_fault) begin
            d_fault = 1'b1;
            d_code  = perm_code;
        end else if (bnd_fault) begin
            d_fault = 1'b1;
            d_code  = EXC_LENGTH;
        end else begin
            d_fault = 1'b0;
            d_code  = EXC_NONE;
        end
    end

    // Register the data response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_code   <= EXC_NONE;
            rsp_regnum <= 8'h00;
            rsp_addr   <= '0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_fault  <= d_fault;
                rsp_code   <= d_code;
                rsp_regnum <= REG_DATA_CAP;
                rsp_addr   <= bnd_vaddr;
            end
        end
    end

    // Register the fetch response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fetch_rsp_valid <= 1'b0;
            fetch_addr_err  <= 1'b0;
            fetch_len_fault <= 1'b0;
            fetch_code      <= EXC_NONE;
            fetch_regnum    <= 8'h00;
            fetch_pc        <= '0;
        end else begin
            fetch_rsp_valid <= fetch_valid;
            if (fetch_valid) begin
                fetch_addr_err  <= f_mis;
                fetch_len_fault <= f_len;
                fetch_code      <= f_len ? EXC_LENGTH : EXC_NONE;
                fetch_regnum    <= f_len ? REG_NONE : 8'h00;
                fetch_pc        <= f_pc;
            end
        end
    end

    // R2
    tag_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !cap_tag |=> rsp_fault && rsp_code == EXC_TAG);

    // R3
    seal_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cap_tag && cap_sealed |=> rsp_fault && rsp_code == EXC_SEAL);

    // R8
    clean_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_fault |-> rsp_code == EXC_NONE);

    // R9
    misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid && (pcc_base[1:0] + pcc_offset[1:0]) != 2'b00
        |=> fetch_addr_err && !fetch_len_fault);

    // R10
    fetch_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_rsp_valid && fetch_len_fault
        |-> fetch_regnum == REG_NONE && fetch_code == EXC_LENGTH);

endmodule

// File: tb/sim_cap_access_checker.sv
module sim_cap_access_checker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        cap_tag = 1'b0;
    logic        cap_sealed = 1'b0;
    logic        cap_perm_exec = 1'b0;
    logic        cap_perm_load = 1'b0;
    logic        cap_perm_store = 1'b0;
    logic [63:0] cap_base = '0;
    logic [63:0] cap_offset = '0;
    logic [63:0] cap_length = '0;
    logic [63:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic [1:0]  acc_size_sel = '0;
    logic        fetch_valid = 1'b0;
    logic [63:0] pcc_base = '0;
    logic [63:0] pcc_offset = '0;
    logic [63:0] pcc_length = '0;
    logic        rsp_valid, rsp_fault;
    logic [7:0]  rsp_code, rsp_regnum;
    logic [63:0] rsp_addr;
    logic        fetch_rsp_valid, fetch_addr_err, fetch_len_fault;
    logic [7:0]  fetch_code, fetch_regnum;
    logic [63:0] fetch_pc;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cap_access_checker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .cap_tag(cap_tag), .cap_sealed(cap_sealed),
        .cap_perm_exec(cap_perm_exec), .cap_perm_load(cap_perm_load),
        .cap_perm_store(cap_perm_store), .cap_base(cap_base),
        .cap_offset(cap_offset), .cap_length(cap_length),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_size_sel(acc_size_sel),
        .fetch_valid(fetch_valid), .pcc_base(pcc_base),
        .pcc_offset(pcc_offset), .pcc_length(pcc_length),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code),
        .rsp_regnum(rsp_regnum), .rsp_addr(rsp_addr),
        .fetch_rsp_valid(fetch_rsp_valid), .fetch_addr_err(fetch_addr_err),
        .fetch_len_fault(fetch_len_fault), .fetch_code(fetch_code),
        .fetch_regnum(fetch_regnum), .fetch_pc(fetch_pc)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one data request at a falling edge; check the response one clock later.
    task automatic do_data(input logic t, input logic s, input logic px,
                           input logic pl, input logic ps,
                           input logic [63:0] b, input logic [63:0] o,
                           input logic [63:0] l, input logic [63:0] a,
                           input logic [1:0] k, input logic [1:0] sz);
        logic [63:0] cur;
        logic [65:0] v, e, lim;
        logic        need;
        logic [7:0]  pcode, ecode;
        string       req;
        req_valid = 1'b1; cap_tag = t; cap_sealed = s;
        cap_perm_exec = px; cap_perm_load = pl; cap_perm_store = ps;
        cap_base = b; cap_offset = o; cap_length = l; acc_addr = a;
        acc_kind = k; acc_size_sel = sz;
        cur = b + o;
        v   = {2'b00, cur} + {2'b00, a};
        e   = v + (66'd1 << sz);
        lim = {2'b00, b} + {2'b00, l};
        need  = (k == 2'd0) ? px : (k == 2'd1) ? pl : ps;
        pcode = (k == 2'd0) ? 8'h11 : (k == 2'd1) ? 8'h12 : 8'h13;
        if (!t) begin ecode = 8'h02; req = "R2"; end
        else if (s) begin ecode = 8'h03; req = "R3"; end
        else if (!need) begin ecode = pcode; req = "R4"; end
        else if (e > lim || v < {2'b00, b}) begin ecode = 8'h01; req = "R6 R7"; end
        else begin ecode = 8'h00; req = "R8"; end
        @(negedge clk);
        check(rsp_valid === 1'b1, "R1", "rsp_valid", 128'(rsp_valid), 128'd1);
        check(rsp_code === ecode && rsp_fault === (ecode != 8'h00) && rsp_regnum === 8'h00,
              req, "code/fault/regnum",
              {rsp_fault, rsp_code, rsp_regnum}, {(ecode != 8'h00), ecode, 8'h00});
        check(rsp_addr === v[63:0], "R5", "rsp_addr", 128'(rsp_addr), 128'(v[63:0]));
    endtask

    // Drive one fetch request at a falling edge; check the response one clock later.
    task automatic do_fetch(input logic [63:0] b, input logic [63:0] o,
                            input logic [63:0] l);
        logic [63:0] pc;
        logic        mis, lf;
        fetch_valid = 1'b1; pcc_base = b; pcc_offset = o; pcc_length = l;
        pc  = b + o;
        mis = |pc[1:0];
        lf  = !mis && (({1'b0, o} + 65'd4) > {1'b0, l});
        @(negedge clk);
        check(fetch_rsp_valid === 1'b1, "R1", "fetch_rsp_valid",
              128'(fetch_rsp_valid), 128'd1);
        check(fetch_pc === pc && fetch_addr_err === mis, "R9", "pc/addr_err",
              {fetch_addr_err, fetch_pc}, {mis, pc});
        check(fetch_len_fault === lf && fetch_code === (lf ? 8'h01 : 8'h00)
              && fetch_regnum === (lf ? 8'hFF : 8'h00), "R10", "len/code/regnum",
              {fetch_len_fault, fetch_code, fetch_regnum},
              {lf, (lf ? 8'h01 : 8'h00), (lf ? 8'hFF : 8'h00)});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check(rsp_valid === 1'b0 && fetch_rsp_valid === 1'b0 && rsp_code === 8'h00
              && rsp_addr === 64'h0 && fetch_pc === 64'h0, "R1", "reset state",
              {rsp_valid, fetch_rsp_valid, rsp_code}, 128'd0);
        rst_n = 1'b1;

        // R2 R3 R4: every tag/seal/permission/kind combination, in bounds
        for (int m = 0; m < 32; m++) begin
            for (int k = 0; k < 4; k++) begin
                do_data(m[4], m[3], m[2], m[1], m[0], 64'h1000, 64'h10, 64'h100,
                        64'h8, 2'(k), 2'd3);
            end
        end

        // R6 R7: offsets across both bounds, every size
        for (int o = 0; o < 84; o++) begin
            for (int a = 0; a < 2; a++) begin
                for (int sz = 0; sz < 4; sz++) begin
                    do_data(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h100, 64'(o) - 64'd8,
                            64'h40, 64'(a), 2'd1, 2'(sz));
                end
            end
        end

        // R5 R6 R7: wrap cases near 2^64
        do_data(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8,
                64'h20, 64'h4, 2'd2, 2'd3);
        do_data(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h18,
                64'h20, 64'h0, 2'd1, 2'd0);
        do_data(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8,
                64'h20, 64'h10, 2'd1, 2'd3);
        do_data(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'h8,
                64'h20, 64'h20, 2'd1, 2'd0);
        do_data(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 64'h0, 64'h0,
                64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFF8, 2'd0, 2'd3);

        // R1: valid drops one clock after the request does
        req_valid = 1'b0;
        @(negedge clk);
        check(rsp_valid === 1'b0, "R1", "rsp_valid idle", 128'(rsp_valid), 128'd0);

        // R9 R10: fetch alignment and length sweep
        for (int b = 0; b < 4; b++) begin
            for (int o = 0; o < 21; o++) begin
                for (int li = 0; li < 4; li++) begin
                    do_fetch(64'h2000 + 64'(b), 64'(o),
                             (li == 0) ? 64'h0 : (li == 1) ? 64'h8 :
                             (li == 2) ? 64'h10 : 64'h13);
                end
            end
        end
        // R10: offset + 4 crosses 2^64 without wrapping
        do_fetch(64'h4, 64'hFFFF_FFFF_FFFF_FFFC, 64'hFFFF_FFFF_FFFF_FFFF);
        fetch_valid = 1'b0;
        @(negedge clk);
        check(fetch_rsp_valid === 1'b0, "R1", "fetch_rsp_valid idle",
              128'(fetch_rsp_valid), 128'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule